// File: doc/BRIEF.md
# I2C Serial Memory Slave Front End

This block is the bus-facing part of a two-wire serial byte memory. It runs on a fast system clock and sees SCL and SDA only through oversampled inputs. From those samples it finds bus conditions and frames each bit and byte. It acknowledges the bytes it accepts and drives data bytes back to the master. The memory array sits behind it on a simple byte interface. Each accepted write byte comes out as a one-cycle strobe with the byte value. A read byte is taken from `rd_byte` in the cycle that `rd_strobe` pulses, and the memory side then moves on to the next byte.

The controller has eight states. `S_IDLE` waits for a Start. `S_ADDR` shifts in the address byte. `S_AACK` holds the acknowledge for the address. `S_WDATA` shifts in a write byte and `S_WACK` acknowledges it. `S_RDATA` shifts a byte out and `S_RACK` samples the master's acknowledge. `S_IGN` stays silent until the next bus condition.

The transitions are as follows. A Start moves any state to `S_ADDR`, and a Stop moves any state to `S_IDLE`. The other transitions happen only on a falling SCL edge:
- `S_ADDR` goes to `S_AACK` after a full byte that matches the device address while the part is not busy, and to `S_IGN` after any other full byte.
- `S_AACK` goes to `S_RDATA` or `S_WDATA`, depending on the direction bit.
- `S_WDATA` goes to `S_WACK` after a full byte, or to `S_IGN` if the part is busy.
- `S_WACK` goes back to `S_WDATA`.
- `S_RDATA` goes to `S_RACK` after a full byte.
- `S_RACK` goes to `S_RDATA` when the master acknowledged, and to `S_IGN` when it did not.

While the external programming-busy input is high, no byte is acknowledged. This lets a master poll the part by sending its address until an acknowledge comes back.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe`, `wr_strobe` and `rd_strobe` are low and the block is idle.
- R2: A Start is recognised when the synchronised SDA falls while the synchronised SCL is high. It begins reception of the address byte. SDA changes while SCL is low are not bus conditions.
- R3: A Stop is recognised when SDA rises while SCL is high. It returns the block to idle, and clock pulses after it draw no acknowledge until the next Start.
- R4: The first byte after a Start is received MSB first. Bits 7..1 are compared with `DEV_ADDR`, and bit 0 selects read (1) or write (0). On a match while `busy_in` is low, `sda_oe` is high through the whole ninth clock pulse, so SDA reads low while SCL is high.
- R5: `sda_oe` changes only in the cycle after a detected SCL falling edge, a Start or a Stop.
- R6: When the address does not match, the block drives nothing until the next Start or Stop.
- R7: While `busy_in` is high, neither an address byte nor a data byte is acknowledged. A data byte received while busy is not strobed, and the block stays silent until the next Start or Stop.
- R8: After an acknowledged write address, every further byte produces one `wr_strobe` pulse carrying that byte on `wr_byte`, and is acknowledged. There is no limit on the number of bytes.
- R9: After an acknowledged read address, the block takes `rd_byte` with a `rd_strobe` pulse and drives it MSB first. Each acknowledge from the master takes and sends the next byte.
- R10: When the master does not acknowledge a read byte, SDA is released, no further byte is taken, and the block stays silent until the next Start or Stop.
- R11: A Start in the middle of a byte aborts that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| busy_in | input | 1 | Internal programming cycle in progress |
| wr_strobe | output | 1 | One-cycle pulse for each accepted write byte |
| wr_byte | output | BYTE_W | Byte that goes with `wr_strobe` |
| rd_strobe | output | 1 | One-cycle pulse when `rd_byte` is taken |
| rd_byte | input | BYTE_W | Next byte from the memory side |

## Verification
Two events can coincide in this block. A Start can land while a byte is only partly shifted, so condition detection preempts the bit framing. The bench provokes this by raising SCL with SDA released after three data bits and then pulling SDA low. It then judges that the following address byte is framed from bit 7 and acknowledged. The second case is the busy input at the moment the acknowledge decision falls on the eighth-bit falling edge. The bench holds busy across that edge for an address byte and for a data byte, and requires SDA to stay released and no write strobe to appear.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK,
        S_IGN
    } slv_state_e;

endpackage

// File: rtl/i2c_line_cond.sv
// Synchronises SCL/SDA and derives SCL edges and bus conditions.
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_ff[SYNC_STAGES-1];
            sda_q  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_STAGES-1];
    assign sda_s     = sda_ff[SYNC_STAGES-1];
    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_evt =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_evt  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_shreg.sv
// Parallel-load left shift register shared by receive and transmit.
module i2c_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int                BYTE_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              busy_in,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_strobe,
    input  logic [BYTE_W-1:0] rd_byte
);
    localparam int              CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    slv_state_e        state, nstate;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sh_q;
    logic              sh_load, sh_shift, sh_bit;
    logic              rw_q, mack_q, oe_q;
    logic              byte_full, addr_hit, cond_evt;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_shreg #(.W(BYTE_W)) u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(rd_byte),
        .shift   (sh_shift),
        .bit_in  (sh_bit),
        .q       (sh_q)
    );

    assign cond_evt  = start_evt | stop_evt;
    assign byte_full = (bit_cnt == FULL);
    assign addr_hit  = (sh_q[BYTE_W-1:1] == DEV_ADDR) && !busy_in;

    // Next-state logic
    always_comb begin
        nstate = state;
        if (start_evt) begin
            nstate = S_ADDR;
        end else if (stop_evt) begin
            nstate = S_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                S_IDLE:  nstate = S_IDLE;
                S_ADDR:  if (byte_full) nstate = addr_hit ? S_AACK : S_IGN;
                S_AACK:  nstate = rw_q ? S_RDATA : S_WDATA;
                S_WDATA: if (byte_full) nstate = busy_in ? S_IGN : S_WACK;
                S_WACK:  nstate = S_WDATA;
                S_RDATA: if (byte_full) nstate = S_RACK;
                S_RACK:  nstate = mack_q ? S_RDATA : S_IGN;
                S_IGN:   nstate = S_IGN;
            endcase
        end
    end

    // Shifter control
    always_comb begin
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_bit   = 1'b1;
        if (!cond_evt) begin
            if ((state == S_ADDR || state == S_WDATA) && scl_rise && !byte_full) begin
                sh_shift = 1'b1;
                sh_bit   = sda_s;
            end
            if (scl_fall && nstate == S_RDATA && (state == S_AACK || state == S_RACK))
                sh_load = 1'b1;
            if (scl_fall && state == S_RDATA && !byte_full)
                sh_shift = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Outputs and framing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            oe_q      <= 1'b0;
            wr_strobe <= 1'b0;
            wr_byte   <= '0;
            rd_strobe <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            rd_strobe <= sh_load;
            if (cond_evt || (scl_fall && nstate != state))
                bit_cnt <= '0;
            else if (scl_rise && !byte_full &&
                     (state == S_ADDR || state == S_WDATA || state == S_RDATA))
                bit_cnt <= bit_cnt + 1'b1;
            if (state == S_ADDR && nstate == S_AACK)
                rw_q <= sh_q[0];
            if (state == S_RACK && scl_rise)
                mack_q <= !sda_s;
            if (state == S_WDATA && nstate == S_WACK) begin
                wr_strobe <= 1'b1;
                wr_byte   <= sh_q;
            end
            if (cond_evt) begin
                oe_q <= 1'b0;
            end else if (scl_fall) begin
                case (nstate)
                    S_AACK, S_WACK: oe_q <= 1'b1;
                    S_RDATA:        oe_q <= sh_load ? ~rd_byte[BYTE_W-1] : ~sh_q[BYTE_W-2];
                    default:        oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
    import i2c_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input slv_state_e st,
    input logic       scl_fall,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       sda_oe,
    input logic       busy_in,
    input logic       wr_strobe,
    input logic       rd_strobe
);
    a_r3_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (st == S_IDLE));

    a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (st == S_ADDR && !sda_oe));

    a_r5_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_oe));

    a_r7_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && (st == S_AACK || st == S_WACK)) |-> !$past(busy_in));

    a_r6_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IGN || st == S_IDLE) |-> !sda_oe);

    a_r10_release_on_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RACK) |-> !sda_oe);

    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && rd_strobe));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (state),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe),
    .busy_in  (busy_in),
    .wr_strobe(wr_strobe),
    .rd_strobe(rd_strobe)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic       sda_oe, wr_strobe, rd_strobe;
    logic [7:0] wr_byte, rd_byte;
    logic       sda_bus;
    logic [7:0] mem [0:15];
    int         ptr = 0;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    logic exp_oe = 1'b0;
    bit   chk_en = 1'b0;
    string cur_tag = "R1";
    logic [7:0] wr_got[$];
    logic [7:0] wr_exp[$];
    int   exp_loads = 0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_byte = mem[ptr[3:0]];

    always @(posedge clk) if (rd_strobe) ptr <= ptr + 1;

    i2c_mem_slave i_i2c_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .busy_in(busy), .wr_strobe(wr_strobe),
        .wr_byte(wr_byte), .rd_strobe(rd_strobe), .rd_byte(rd_byte)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic half(input logic eo, input bit en);
        chk_en = 1'b0;
        exp_oe = eo;
        repeat (5) @(negedge clk);
        chk_en = en;
        repeat (H - 5) @(negedge clk);
        chk_en = 1'b0;
    endtask

    task automatic do_start();
        sda_m = 1'b1; half(1'b0, 1'b0);
        scl_m = 1'b1; half(1'b0, 1'b0);
        sda_m = 1'b0; half(1'b0, 1'b1);
        scl_m = 1'b0;
    endtask

    task automatic do_stop();
        sda_m = 1'b0; half(1'b0, 1'b0);
        scl_m = 1'b1; half(1'b0, 1'b0);
        sda_m = 1'b1; half(1'b0, 1'b1);
    endtask

    task automatic bit_clk(input logic b, input logic eo);
        sda_m = b;    half(eo, 1'b1);
        scl_m = 1'b1; half(eo, 1'b1);
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d, input logic ack, input string tag);
        cur_tag = tag;
        for (int i = 7; i >= 0; i--) bit_clk(d[i], 1'b0);
        sda_m = 1'b1; half(ack, 1'b1);
        scl_m = 1'b1; half(ack, 1'b1);
        check(sda_bus == !ack, tag, sda_bus, !ack);
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic [7:0] d, input logic mack, input string tag);
        cur_tag = tag;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; half(!d[i], 1'b1);
            scl_m = 1'b1; half(!d[i], 1'b1);
            check(sda_bus == d[i], tag, sda_bus, d[i]);
            scl_m = 1'b0;
        end
        sda_m = !mack; half(1'b0, 1'b1);
        scl_m = 1'b1;  half(1'b0, 1'b1);
        scl_m = 1'b0;
    endtask

    task automatic cmp_writes(input string tag);
        check(wr_got.size() == wr_exp.size(), tag, wr_got.size(), wr_exp.size());
        for (int i = 0; i < wr_exp.size() && i < wr_got.size(); i++)
            check(wr_got[i] == wr_exp[i], tag, wr_got[i], wr_exp[i]);
        wr_got.delete();
        wr_exp.delete();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(8'h5A ^ (i * 37));
        fork
            forever begin
                @(negedge clk);
                if (chk_en) check(sda_oe == exp_oe, cur_tag, sda_oe, exp_oe);
                if (wr_strobe) wr_got.push_back(wr_byte);
            end
        join_none

        // R1: reset state
        repeat (3) @(negedge clk);
        check(sda_oe == 1'b0, "R1", sda_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sda_oe == 1'b0 && !wr_strobe && !rd_strobe, "R1",
              {sda_oe, wr_strobe, rd_strobe}, 0);

        // R2 R4 R8: write address then unbounded data bytes
        do_start();
        write_byte(8'hA0, 1'b1, "R4");
        write_byte(8'h3C, 1'b1, "R8"); wr_exp.push_back(8'h3C);
        write_byte(8'hA5, 1'b1, "R2"); wr_exp.push_back(8'hA5);
        write_byte(8'h00, 1'b1, "R8"); wr_exp.push_back(8'h00);
        write_byte(8'hFF, 1'b1, "R8"); wr_exp.push_back(8'hFF);
        do_stop();
        cmp_writes("R8");

        // R3: clock pulses after Stop draw no acknowledge
        scl_m = 1'b0;
        write_byte(8'hA0, 1'b0, "R3");
        write_byte(8'h11, 1'b0, "R3");
        scl_m = 1'b1; do_stop();
        cmp_writes("R3");

        // R6: address mismatch
        do_start();
        write_byte(8'hA2, 1'b0, "R6");
        write_byte(8'h77, 1'b0, "R6");
        do_stop();
        cmp_writes("R6");

        // R7: busy on the address byte, then on a data byte
        busy = 1'b1;
        do_start();
        write_byte(8'hA0, 1'b0, "R7");
        do_stop();
        busy = 1'b0;
        do_start();
        write_byte(8'hA0, 1'b1, "R7");
        write_byte(8'h42, 1'b1, "R7"); wr_exp.push_back(8'h42);
        busy = 1'b1;
        write_byte(8'h43, 1'b0, "R7");
        busy = 1'b0;
        write_byte(8'h44, 1'b0, "R7");
        do_stop();
        cmp_writes("R7");

        // R9 R10: read burst ending with master NACK
        do_start();
        write_byte(8'hA1, 1'b1, "R4");
        read_byte(mem[exp_loads[3:0]], 1'b1, "R9"); exp_loads++;
        read_byte(mem[exp_loads[3:0]], 1'b1, "R9"); exp_loads++;
        read_byte(mem[exp_loads[3:0]], 1'b0, "R10"); exp_loads++;
        cur_tag = "R10";
        bit_clk(1'b1, 1'b0);
        bit_clk(1'b0, 1'b0);
        @(negedge clk);
        check(ptr == exp_loads, "R10", ptr, exp_loads);
        sda_m = 1'b1;
        do_stop();

        // R11: repeated Start in the middle of a write byte
        do_start();
        write_byte(8'hA0, 1'b1, "R11");
        cur_tag = "R11";
        bit_clk(1'b1, 1'b0);
        bit_clk(1'b0, 1'b0);
        bit_clk(1'b1, 1'b0);
        do_start();
        write_byte(8'hA1, 1'b1, "R11");
        read_byte(mem[exp_loads[3:0]], 1'b0, "R11"); exp_loads++;
        sda_m = 1'b1;
        do_stop();
        check(ptr == exp_loads, "R11", ptr, exp_loads);
        cmp_writes("R11");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule